// File: doc/BRIEF.md
# Range Translation Cache

This block caches range translations next to the second-level data TLB. Each entry covers a contiguous span of virtual pages, from a lower page number to an upper page number with both ends included. Those pages map to a contiguous span of physical pages through one signed displacement. All pages in a range share a single protection field.

After a first-level TLB miss, the surrounding logic presents a virtual page number. All entries compare it against their bounds at the same time. One cycle later the block answers with a hit flag, a physical page number and the protection bits, which together form a single-page entry to refill the first-level TLB. If both this block and the second-level TLB miss, a page walk starts outside the block. A range fetched later by a background range-table walk comes back through the insert port.

Inserts fill free entries first. Once the cache is full, a round-robin pointer picks the victim. An insert with bounds equal to those of a valid entry rewrites that entry. A flush drops every entry in one cycle.

Top module: `range_tlb`

## Requirements
- R1: A valid entry matches a lookup page number V when base <= V and V <= limit (unsigned, both bounds inclusive); every other page number misses in that entry.
- R2: On a hit the physical page number is (V + offset) modulo 2^VPN_W, where offset is taken as two's complement, and the protection output equals the matching entry's stored protection.
- R3: The response appears exactly one cycle after the lookup strobe: rsp_valid is high only in the cycle after lkp_valid. A miss response drives rsp_ppn and rsp_prot to zero.
- R4: An insert whose bounds match no valid entry is written into the lowest-index invalid entry, if one exists.
- R5: When every entry is valid and the bounds match none of them, the insert overwrites the entry at the replacement pointer. The pointer starts at 0, advances by one after each such replacement, and wraps after ENTRIES-1.
- R6: An insert whose base and limit both equal those of a valid entry updates that entry's offset and protection in place. It adds no entry and leaves the replacement pointer unchanged.
- R7: A flush invalidates all entries and resets the replacement pointer to 0. A lookup in the flush cycle reports a miss, and an insert in the flush cycle is dropped.
- R8: If several valid entries match a lookup, the lowest-index one supplies the translation.
- R9: During and right after reset no entry is valid and rsp_valid and rsp_hit are low.
- R10: A lookup in the same cycle as an insert is answered from the contents before that insert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after lookup |
| rsp_hit | output | 1 | Lookup matched a range |
| rsp_ppn | output | VPN_W | Translated physical page number (zero on miss) |
| rsp_prot | output | PROT_W | Protection of the matching range (zero on miss) |
| ins_valid | input | 1 | Insert request strobe |
| ins_base | input | VPN_W | First virtual page of the range |
| ins_limit | input | VPN_W | Last virtual page of the range |
| ins_offset | input | VPN_W | Two's complement page displacement |
| ins_prot | input | PROT_W | Protection bits for the range |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench sets ENTRIES to 4 and keeps VPN_W at 36 and PROT_W at 4. With only four entries the cache fills after a few inserts, so replacement, pointer wrap, in-place update and pointer reset after a flush are all reached in a short run. The full 36-bit page number lets a negative displacement and a translation that wraps past the top of the page space be checked. Overlapping ranges exercise the lowest-index priority, and a mixed sequence of lookups, inserts and flushes is compared against the reference model on every cycle.

// File: rtl/range_tlb.sv
module range_tlb #(
  parameter int VPN_W   = 36,
  parameter int PROT_W  = 4,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [VPN_W-1:0]  lkp_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [VPN_W-1:0]  rsp_ppn,
  output logic [PROT_W-1:0] rsp_prot,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_base,
  input  logic [VPN_W-1:0]  ins_limit,
  input  logic [VPN_W-1:0]  ins_offset,
  input  logic [PROT_W-1:0] ins_prot,
  input  logic              flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   base_q  [ENTRIES];
  logic [VPN_W-1:0]   limit_q [ENTRIES];
  logic [VPN_W-1:0]   off_q   [ENTRIES];
  logic [PROT_W-1:0]  prot_q  [ENTRIES];
  logic [IDX_W-1:0]   vict_q;

  logic [ENTRIES-1:0] hit_vec, same_vec;
  logic [IDX_W-1:0]   hit_idx, same_idx, free_idx, wr_idx;
  logic               any_hit, any_same, any_free, do_wr;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i]  = valid_q[i] && (lkp_vpn >= base_q[i]) && (lkp_vpn <= limit_q[i]);
    assign same_vec[i] = valid_q[i] && (ins_base == base_q[i]) && (ins_limit == limit_q[i]);
  end

  assign any_hit  = |hit_vec;
  assign any_same = |same_vec;
  assign any_free = ~&valid_q;

  always_comb begin
    hit_idx  = '0;
    same_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx  = IDX_W'(i);
      if (same_vec[i]) same_idx = IDX_W'(i);
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign wr_idx = any_same ? same_idx : (any_free ? free_idx : vict_q);
  assign do_wr  = ins_valid && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      vict_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_prot  <= '0;
    end else begin
      rsp_valid <= lkp_valid;
      rsp_hit   <= lkp_valid && !flush && any_hit;
      rsp_ppn   <= (lkp_valid && !flush && any_hit) ? lkp_vpn + off_q[hit_idx] : '0;
      rsp_prot  <= (lkp_valid && !flush && any_hit) ? prot_q[hit_idx] : '0;
      if (flush) begin
        valid_q <= '0;
        vict_q  <= '0;
      end else if (ins_valid) begin
        valid_q[wr_idx] <= 1'b1;
        if (!any_same && !any_free)
          vict_q <= (vict_q == LAST) ? '0 : vict_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      base_q[wr_idx]  <= ins_base;
      limit_q[wr_idx] <= ins_limit;
      off_q[wr_idx]   <= ins_offset;
      prot_q[wr_idx]  <= ins_prot;
    end
  end

  AST_RSP_FOLLOWS_LKP: assert property (@(posedge clk) disable iff (!rst_n) lkp_valid |=> rsp_valid); // R3
  AST_NO_RSP_WITHOUT_LKP: assert property (@(posedge clk) disable iff (!rst_n) !lkp_valid |=> !rsp_valid && !rsp_hit); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_hit |-> rsp_ppn == '0 && rsp_prot == '0); // R3
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !rsp_hit); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> valid_q == '0 && vict_q == '0); // R7
  AST_INSERT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n) ins_valid && !flush |=> valid_q != '0); // R4
  AST_UPDATE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n) ins_valid && !flush && any_same |=> $stable(vict_q) && $stable(valid_q)); // R6
endmodule

// File: tb/sim_range_tlb.sv
`timescale 1ns/1ps
module sim_range_tlb;
  localparam int VW = 36, PW = 4, N = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic lkp_valid = 1'b0, ins_valid = 1'b0, flush = 1'b0;
  logic [VW-1:0] lkp_vpn = '0, ins_base = '0, ins_limit = '0, ins_offset = '0;
  logic [PW-1:0] ins_prot = '0;
  logic rsp_valid, rsp_hit;
  logic [VW-1:0] rsp_ppn;
  logic [PW-1:0] rsp_prot;

  range_tlb #(.VPN_W(VW), .PROT_W(PW), .ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot),
    .ins_valid(ins_valid), .ins_base(ins_base), .ins_limit(ins_limit),
    .ins_offset(ins_offset), .ins_prot(ins_prot), .flush(flush));

  int errors = 0, checks = 0;
  string cur_req = "R9";

  bit            m_val [N];
  logic [VW-1:0] m_base[N], m_lim[N], m_off[N];
  logic [PW-1:0] m_prot[N];
  int            m_ptr = 0;
  logic          e_valid = 0, e_hit = 0;
  logic [VW-1:0] e_ppn = '0;
  logic [PW-1:0] e_prot = '0;

  task automatic model();
    int slot;
    if (!rst_n) begin
      foreach (m_val[i]) m_val[i] = 0;
      m_ptr = 0; e_valid = 0; e_hit = 0; e_ppn = '0; e_prot = '0;
      return;
    end
    e_valid = lkp_valid; e_hit = 0; e_ppn = '0; e_prot = '0;
    if (lkp_valid && !flush)
      for (int i = 0; i < N; i++)
        if (!e_hit && m_val[i] && lkp_vpn >= m_base[i] && lkp_vpn <= m_lim[i]) begin
          e_hit = 1; e_ppn = lkp_vpn + m_off[i]; e_prot = m_prot[i];
        end
    if (flush) begin
      foreach (m_val[i]) m_val[i] = 0;
      m_ptr = 0;
    end else if (ins_valid) begin
      slot = -1;
      for (int i = 0; i < N; i++)
        if (slot < 0 && m_val[i] && m_base[i] == ins_base && m_lim[i] == ins_limit) slot = i;
      if (slot < 0)
        for (int i = 0; i < N; i++)
          if (slot < 0 && !m_val[i]) slot = i;
      if (slot < 0) begin
        slot = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_val[slot] = 1; m_base[slot] = ins_base; m_lim[slot] = ins_limit;
      m_off[slot] = ins_offset; m_prot[slot] = ins_prot;
    end
  endtask

  task automatic chk(input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [VW-1:0] v,
                      input logic iv, input logic [VW-1:0] b, input logic [VW-1:0] l,
                      input logic [VW-1:0] o, input logic [PW-1:0] p, input logic fl);
    lkp_valid = lv; lkp_vpn = v; ins_valid = iv; ins_base = b; ins_limit = l;
    ins_offset = o; ins_prot = p; flush = fl;
    @(posedge clk);
    model();
    @(negedge clk);
    chk("rsp_valid", VW'(rsp_valid), VW'(e_valid));
    chk("rsp_hit", VW'(rsp_hit), VW'(e_hit));
    chk("rsp_ppn", rsp_ppn, e_ppn);
    chk("rsp_prot", VW'(rsp_prot), VW'(e_prot));
  endtask

  task automatic lk(input logic [VW-1:0] v);
    step(1, v, 0, '0, '0, '0, '0, 0);
  endtask
  task automatic ins(input logic [VW-1:0] b, input logic [VW-1:0] l, input logic [VW-1:0] o, input logic [PW-1:0] p);
    step(0, '0, 1, b, l, o, p, 0);
  endtask
  task automatic expect_hit(input string req, input logic want);
    checks++;
    if (rsp_hit !== want) begin
      errors++;
      $display("FAIL %s direct hit: actual=%b expected=%b", req, rsp_hit, want);
    end
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R9";
    repeat (3) step(1, 36'h100, 0, '0, '0, '0, '0, 0);
    rst_n = 1'b1;
    lk(36'h100); expect_hit("R9", 0);

    cur_req = "R4";
    ins(36'h100, 36'h1FF, 36'h1000, 4'h3);
    ins(36'h400, 36'h40F, -36'sh300, 4'h5);

    cur_req = "R1";
    lk(36'h100); expect_hit("R1", 1);
    lk(36'h1FF); expect_hit("R1", 1);
    lk(36'h0FF); expect_hit("R1", 0);
    lk(36'h200); expect_hit("R1", 0);
    lk(36'h400); lk(36'h40F); lk(36'h410);

    cur_req = "R2";
    lk(36'h150); lk(36'h405);
    ins(36'hFFFFFFF00, 36'hFFFFFFFFF, 36'h200, 4'h9);
    lk(36'hFFFFFFFF0);

    cur_req = "R8";
    ins(36'h180, 36'h1A0, 36'h5, 4'h1);
    lk(36'h190);

    cur_req = "R3";
    step(0, 36'h150, 0, '0, '0, '0, '0, 0);
    lk(36'h3000);

    cur_req = "R5";
    ins(36'h800, 36'h8FF, 36'h10, 4'h2);
    lk(36'h150); expect_hit("R5", 0);
    lk(36'h190); expect_hit("R5", 1);
    ins(36'h900, 36'h9FF, 36'h20, 4'h4);
    lk(36'h405); expect_hit("R5", 0);

    cur_req = "R6";
    ins(36'h800, 36'h8FF, 36'h77, 4'h7);
    lk(36'h800);
    ins(36'hA00, 36'hAFF, 36'h30, 4'h6);
    lk(36'hFFFFFFFF0); expect_hit("R6", 0);
    lk(36'h900); expect_hit("R6", 1);

    cur_req = "R10";
    step(1, 36'hB00, 1, 36'hB00, 36'hBFF, 36'h40, 4'h8, 0);
    expect_hit("R10", 0);
    lk(36'hB00); expect_hit("R10", 1);
    ins(36'hC00, 36'hCFF, 36'h50, 4'hA);

    cur_req = "R7";
    step(1, 36'h800, 0, '0, '0, '0, '0, 1);
    expect_hit("R7", 0);
    lk(36'h800); expect_hit("R7", 0);
    step(0, '0, 1, 36'hD00, 36'hDFF, 36'h1, 4'h1, 1);
    lk(36'hD00); expect_hit("R7", 0);
    for (int k = 0; k < 5; k++)
      ins(VW'(36'h1000 + k * 36'h100), VW'(36'h10FF + k * 36'h100), VW'(k), PW'(k));
    lk(36'h1000); expect_hit("R7", 0);
    lk(36'h1100); expect_hit("R7", 1);
    lk(36'h1400);

    cur_req = "R2";
    for (int k = 0; k < 300; k++) begin
      if (k % 7 == 3)
        ins(VW'((k % 9) * 36'h80), VW'((k % 9) * 36'h80 + 36'h7F), VW'(k * 36'h11111), PW'(k));
      else if (k % 53 == 50)
        step(1, VW'(k * 29), 0, '0, '0, '0, '0, 1);
      else if (k % 11 == 5)
        step(1, VW'((k * 37) % 36'h500), 1, VW'((k % 5) * 36'h80), VW'((k % 5) * 36'h80 + 36'hFF), VW'(-k), PW'(k + 1), 0);
      else
        lk(VW'((k * 37) % 36'h500));
    end

    step(0, '0, 0, '0, '0, '0, '0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule